// File: doc/BRIEF.md
# Outstanding-Read Performance Counter Set

This block sits beside a read-issuing master port and measures how deep its read pipeline runs. A strobe marks each accepted read request and another strobe marks each returned read response. From these it keeps four counters: the reads outstanding right now, the deepest outstanding count observed, the integral of the outstanding count over time, and the number of cycles during which at least one read was pending. Dividing the integral by the active-cycle count gives the average occupancy while busy, and the peak shows the worst case.

Software starts a measurement by writing the control register with any data value. The write clears all four counters and arms them. A separate stop strobe freezes them. The counter values are meant to be read only once counting has stopped. The register read path returns the low 32 bits of the integral, and further read ports expose the upper 32 bits, the peak and the active-cycle count.

Top module: `rd_occ_perf`

## Requirements
- R1: After reset, counting is disabled (`en_o` = 0) and every counter output reads zero.
- R2: While counting, the outstanding count rises by one after a cycle with `req_i` alone, falls by one after a cycle with `rsp_i` alone, and is unchanged after a cycle with both or neither.
- R3: While counting, each cycle the peak counter takes the larger of its own value and the current outstanding count, so it never decreases until the next clear.
- R4: In each counting cycle where the outstanding count is nonzero, that count is added to the 64-bit integral and the 48-bit active-cycle counter advances by one; cycles with a zero count change neither.
- R5: A pulse on `cfg_wr_i` clears all four counters to zero on the next edge and sets `en_o`; counting starts in the cycle after that. If `cfg_wr_i` and `stop_i` arrive together, the write wins.
- R6: A pulse on `stop_i` clears `en_o` after the edge; the cycle carrying the stop still counts, and from then on all four counters hold their values whatever `req_i` and `rsp_i` do. Before the first write, the strobes likewise have no effect.
- R7: A response while the outstanding count is 0 is ignored (count stays 0), and a request while the count is 2047 leaves it at 2047.
- R8: `rdata_o` equals bits 31:0 of the integral, `sum_hi_o` equals bits 63:32, `peak_o` the peak and `active_o` the active-cycle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request accepted this cycle |
| rsp_i | input | 1 | Read response returned this cycle |
| cfg_wr_i | input | 1 | Control register write strobe; data ignored; clears and arms |
| stop_i | input | 1 | Stops counting |
| en_o | output | 1 | Counting enabled |
| occ_o | output | 11 | Reads currently outstanding |
| peak_o | output | 11 | Highest outstanding count seen |
| rdata_o | output | 32 | Register read data: integral bits 31:0 |
| sum_hi_o | output | 32 | Integral bits 63:32 |
| active_o | output | 48 | Cycles with at least one read outstanding |

## Verification
The bench drives the outstanding count to zero and then keeps returning responses, which a design without the underflow guard would wrap to 2047 and pour into the integral. It issues more than 2047 back-to-back requests to reach the ceiling, where a missing guard would roll the count to zero and collapse the peak reading, and it pairs request and response at that ceiling and at zero, where a design that handled only one strobe would step. It also collides the control write with the stop strobe and sends strobes while stopped: a wrong priority would leave counting off, and a leaky enable would move frozen values or keep the stop cycle out of the totals.

// File: rtl/rd_occ_pkg.sv
package rd_occ_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/rd_occ_ctrl.sv
module rd_occ_ctrl
  import rd_occ_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic stop_i,
  output logic en_o,
  output logic clr_o
);
  run_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_IDLE;
    else if (cfg_wr_i) state_q <= ST_RUN;   // write beats stop
    else if (stop_i)   state_q <= ST_IDLE;
  end

  assign en_o  = (state_q == ST_RUN);
  assign clr_o = cfg_wr_i;

  AST_WR_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> en_o); // R5
  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !cfg_wr_i) |=> !en_o); // R6
endmodule

// File: rtl/rd_occ_track.sv
module rd_occ_track #(
  parameter int OCC_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic             rsp_i,
  output logic [OCC_W-1:0] occ_o,
  output logic [OCC_W-1:0] peak_o
);
  localparam logic [OCC_W-1:0] OCC_MAX = {OCC_W{1'b1}};
  localparam logic [OCC_W-1:0] OCC_ONE = OCC_W'(1);

  logic [OCC_W-1:0] occ_q, occ_d, peak_q;

  always_comb begin
    occ_d = occ_q;
    unique case ({req_i, rsp_i})
      2'b10:   if (occ_q != OCC_MAX) occ_d = occ_q + OCC_ONE;
      2'b01:   if (occ_q != '0)      occ_d = occ_q - OCC_ONE;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      peak_q <= '0;
    end else if (clr_i) begin
      occ_q  <= '0;
      peak_q <= '0;
    end else if (en_i) begin
      occ_q <= occ_d;
      if (occ_q > peak_q) peak_q <= occ_q;
    end
  end

  assign occ_o  = occ_q;
  assign peak_o = peak_q;

  AST_OCC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (occ_q == $past(occ_q)) || (occ_q == $past(occ_q) + OCC_ONE)
                        || (occ_q + OCC_ONE == $past(occ_q))); // R2
  AST_PEAK_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> peak_q >= $past(peak_q)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && occ_q == OCC_MAX && req_i) |=> occ_q == OCC_MAX); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && occ_q == '0 && rsp_i) |=> occ_q == '0); // R7
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(occ_q) && $stable(peak_q)); // R6
endmodule

// File: rtl/rd_occ_accum.sv
module rd_occ_accum #(
  parameter int OCC_W = 11,
  parameter int SUM_W = 64,
  parameter int ACT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [OCC_W-1:0] occ_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [ACT_W-1:0] act_o
);
  logic [SUM_W-1:0] sum_q;
  logic [ACT_W-1:0] act_q;
  logic             busy;

  assign busy = (occ_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      act_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      act_q <= '0;
    end else if (en_i && busy) begin
      sum_q <= sum_q + SUM_W'(occ_i);
      act_q <= act_q + ACT_W'(1);
    end
  end

  assign sum_o = sum_q;
  assign act_o = act_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !busy) |=> $stable(sum_q) && $stable(act_q)); // R4
  AST_ACT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && busy) |=> act_q == $past(act_q) + ACT_W'(1)); // R4
  AST_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_q == '0) && (act_q == '0)); // R5
endmodule

// File: rtl/rd_occ_perf.sv
module rd_occ_perf #(
  parameter int OCC_W = 11,
  parameter int SUM_W = 64,
  parameter int ACT_W = 48,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             rsp_i,
  input  logic             cfg_wr_i,
  input  logic             stop_i,
  output logic             en_o,
  output logic [OCC_W-1:0] occ_o,
  output logic [OCC_W-1:0] peak_o,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] sum_hi_o,
  output logic [ACT_W-1:0] active_o
);
  logic             en, clr;
  logic [OCC_W-1:0] occ;
  logic [SUM_W-1:0] sum;

  rd_occ_ctrl u_ctrl (
    .clk_i, .rst_ni, .cfg_wr_i, .stop_i,
    .en_o (en), .clr_o (clr)
  );

  rd_occ_track #(.OCC_W(OCC_W)) u_track (
    .clk_i, .rst_ni, .en_i (en), .clr_i (clr), .req_i, .rsp_i,
    .occ_o (occ), .peak_o
  );

  rd_occ_accum #(.OCC_W(OCC_W), .SUM_W(SUM_W), .ACT_W(ACT_W)) u_accum (
    .clk_i, .rst_ni, .en_i (en), .clr_i (clr), .occ_i (occ),
    .sum_o (sum), .act_o (active_o)
  );

  assign en_o     = en;
  assign occ_o    = occ;
  assign rdata_o  = sum[REG_W-1:0];
  assign sum_hi_o = sum[SUM_W-1:REG_W];

  AST_ACT_LE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {rdata_o, sum_hi_o} != '0 || active_o == '0); // R4
  AST_PEAK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !clr) |=> peak_o >= $past(occ)); // R3
endmodule

// File: tb/rd_occ_perf_test.sv
module rd_occ_perf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, rsp = 1'b0, wr = 1'b0, stp = 1'b0;
  logic        en_o;
  logic [10:0] occ_o, peak_o;
  logic [31:0] rdata_o, sum_hi_o;
  logic [47:0] active_o;

  int n_chk = 0, n_bad = 0;

  // reference state
  bit      m_en = 0;
  int      m_occ = 0, m_peak = 0;
  longint unsigned m_sum = 0, m_act = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  rd_occ_perf uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rsp_i(rsp),
    .cfg_wr_i(wr), .stop_i(stp), .en_o, .occ_o, .peak_o,
    .rdata_o, .sum_hi_o, .active_o
  );

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string ctx);
    chk({"R5/R6 en ", ctx}, en_o, m_en);
    chk({"R2/R7 occ ", ctx}, occ_o, m_occ);
    chk({"R3 peak ", ctx}, peak_o, m_peak);
    chk({"R4/R8 sum_lo ", ctx}, rdata_o, m_sum[31:0]);
    chk({"R4/R8 sum_hi ", ctx}, sum_hi_o, m_sum[63:32]);
    chk({"R4/R8 active ", ctx}, active_o, m_act);
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit rq, bit rs, bit w, bit s, string ctx);
    req = rq; rsp = rs; wr = w; stp = s;
    if (w) begin
      m_occ = 0; m_peak = 0; m_sum = 0; m_act = 0;
    end else if (m_en) begin
      if (m_occ > m_peak) m_peak = m_occ;
      if (m_occ != 0) begin
        m_sum += longint'(m_occ);
        m_act++;
      end
      if (rq && !rs && m_occ < 2047) m_occ++;
      else if (rs && !rq && m_occ > 0) m_occ--;
    end
    if (w) m_en = 1;
    else if (s) m_en = 0;
    @(posedge clk);
    @(negedge clk);
    compare_all(ctx);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // strobes before any write: no effect (R6)
    for (int i = 0; i < 8; i++) step(1, i[0], 0, 0, "R6 pre-enable");

    // arm and run a mixed pattern, biased toward requests (R2 R3 R4)
    step(0, 0, 1, 0, "R5 arm");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], 0, 0, "R2 mixed");
    end
    // drain with responses, then keep responding at zero (R7)
    for (int i = 0; i < 260; i++) step(0, 1, 0, 0, "R7 drain");
    step(1, 1, 0, 0, "R2 both at zero");

    // stop, then strobes while frozen (R6)
    step(1, 0, 0, 0, "R2 one up");
    step(1, 0, 0, 1, "R6 stop cycle counts");
    for (int i = 0; i < 20; i++) step(1, i[1], 0, 0, "R6 frozen");

    // write and stop together: write wins, counters cleared (R5)
    step(0, 0, 1, 1, "R5 write beats stop");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R7 rsp at zero");

    // climb to the ceiling (R7)
    for (int i = 0; i < 2100; i++) step(1, 0, 0, 0, "R7 saturate");
    step(1, 1, 0, 0, "R2 both at ceiling");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R2 down from ceiling");
    step(0, 0, 0, 1, "R6 final stop");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R6 frozen end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule